// File: doc/BRIEF.md
# Port Interrupt Status and Enable Hub

This block gathers interrupt events for a group of storage-link ports and turns them into one interrupt line per port. Each port owns a sticky status word fed by single-cycle event pulses (command done, command failure, port-ready change, power change, PHY-ready change, wake signal seen, unrecognised frame seen, set-device-bits frame seen). Software reads one status word that carries the enabled view and the raw view together. It acknowledges events by writing ones. It controls which sources may interrupt through an enable mask that has separate set and clear addresses. A 2-bit steering value lives next to the mask and is driven out unchanged for routing logic elsewhere.

A host-level stage collects the per-port requests. A host status register shows which ports have an enabled event pending, and a host control register gates each port's line. Every port also keeps an error-code register. It loads when the port reports a failure, and software clears it by writing back the value it read. Writing a different value leaves it alone.

Registers sit on a simple write strobe and address bus with a combinational read port. Address bits 5:3 select the block: values 0 to NPORTS-1 are ports and 7 is the host. Bits 2:0 select the register. Port registers: 0 status, 1 enable set, 2 enable clear, 3 error code. Host registers: 0 host status, 1 host control.

Top module: `port_irq_hub`

## Requirements
- R1: After a synchronous reset, the following are all zero: every status bit, enable bit, steering value, error code and host control bit, and every interrupt line.
- R2: An event pulse on bit 0, 1, 2, 3, 4, 5, 6 or 11 of a port's 12-bit event input sets the same bit of that port's status. Pulses on bits 7 to 10 never set anything, and those status bits always read 0.
- R3: If an event pulse and a write-one-to-clear of the same status bit happen in the same cycle, the bit is set afterwards.
- R4: A write to port offset 0 clears status bit k if wdata bit k or wdata bit k+16 is 1. Bits written as 0 are unchanged, so 0x0FFF0FFF acknowledges everything.
- R5: A read of port offset 0 returns status AND enable in bits 11:0 and the raw status in bits 27:16. All other bits read 0.
- R6: A write to offset 1 sets the enable bits where wdata[11:0] is 1. A write to offset 2 clears them. Only bits 0-6 and 11 exist. A read of either offset returns the enable bits in 11:0 and the steering value in 31:30.
- R7: A write to offset 1 loads wdata[31:30] into the port's steering value in the same access as its enable update, and the value appears on the steer output. A write to offset 2 leaves the steering value unchanged.
- R8: A port's interrupt line is high exactly when its host control bit is 1 and at least one status bit is both set and enabled.
- R9: A read of host offset 0 returns, in bit p, whether port p has a set and enabled status bit, whatever the host control value. Host offset 1 is read/write, one gating bit per port in its low bits.
- R10: A port's error code (offset 3, ERR_W bits, zero-extended) loads the code input whenever the port's error-valid input is high. A write equal to the stored value clears it, and an unequal write is ignored. A load in the same cycle as a clearing write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_pulse | input | NPORTS*12 | Event pulses, 12 bits per port, port p at [12p+11:12p] |
| err_vld | input | NPORTS | Per-port error code load strobe |
| err_code | input | NPORTS*ERR_W | Per-port error code value |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 6 | Register address: block in 5:3, register in 2:0 |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| irq | output | NPORTS | Per-port interrupt lines |
| steer | output | NPORTS*2 | Per-port steering values |

## Verification
The bench goes after several collisions and view bugs. The first is an event landing in the same cycle as its own acknowledge. A design that gave the clear priority would lose that event for good. The second is acknowledging through the upper (raw) half alone, which a design that looks only at the low half would ignore. It also sweeps every event bit on every port, which catches a design that latches the unused bit positions 7 to 10 or shifts the raw view by the wrong amount. The rest of the sweep covers enable patterns and all host-control values, where a swapped mask or a host status that folds in the host gate shows up as a wrong interrupt line or a wrong read. Steering is checked under clear-address writes, and the error code under mismatched write-back and load-versus-clear collisions.

// File: rtl/irqhub_pkg.sv
package irqhub_pkg;

    localparam int DATA_W    = 32;
    localparam int SRC_W     = 12;
    localparam int RAW_LSB   = 16;
    localparam int STEER_LSB = 30;
    localparam int STEER_W   = 2;
    localparam int BLK_W     = 3;
    localparam int OFF_W     = 3;
    localparam int ADDR_W    = BLK_W + OFF_W;

    // Implemented event sources: bits 0..6 and 11
    localparam logic [SRC_W-1:0] SRC_MASK = 12'h87F;
    localparam logic [BLK_W-1:0] HOST_BLK = 3'd7;

    typedef enum logic [OFF_W-1:0] {
        PREG_STAT  = 3'd0,
        PREG_ENSET = 3'd1,
        PREG_ENCLR = 3'd2,
        PREG_ERR   = 3'd3
    } port_reg_e;

    typedef enum logic [OFF_W-1:0] {
        HREG_STAT = 3'd0,
        HREG_CTL  = 3'd1
    } host_reg_e;

    typedef struct packed {
        logic [STEER_W-1:0] steer;
        logic [SRC_W-1:0]   en;
    } en_cfg_t;

    // Acknowledge bits may come from either half of the written word
    function automatic logic [SRC_W-1:0] ack_bits(input logic [DATA_W-1:0] d);
        return (d[SRC_W-1:0] | d[RAW_LSB +: SRC_W]) & SRC_MASK;
    endfunction

    function automatic logic [DATA_W-1:0] stat_word(input logic [SRC_W-1:0] st,
                                                    input logic [SRC_W-1:0] en);
        logic [DATA_W-1:0] w;
        w = '0;
        w[SRC_W-1:0]       = st & en;
        w[RAW_LSB +: SRC_W] = st;
        return w;
    endfunction

    function automatic logic [DATA_W-1:0] en_word(input en_cfg_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[SRC_W-1:0]            = c.en;
        w[STEER_LSB +: STEER_W] = c.steer;
        return w;
    endfunction

endpackage

// File: rtl/irqhub_port.sv
module irqhub_port
    import irqhub_pkg::*;
#(
    parameter int ERR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SRC_W-1:0]  ev,
    input  logic              err_vld,
    input  logic [ERR_W-1:0]  err_code,
    input  logic              wr_stat,
    input  logic              wr_enset,
    input  logic              wr_enclr,
    input  logic              wr_err,
    input  logic [DATA_W-1:0] wdata,
    output logic [SRC_W-1:0]  stat_q,
    output en_cfg_t           cfg_q,
    output logic [ERR_W-1:0]  err_q,
    output logic              pending
);

    logic [SRC_W-1:0] clr_bits;
    logic [SRC_W-1:0] stat_d;
    logic             err_match;

    assign clr_bits  = wr_stat ? ack_bits(wdata) : '0;
    // Clear first, then OR in new events so a colliding event survives
    assign stat_d    = (stat_q & ~clr_bits) | (ev & SRC_MASK);
    assign err_match = (wdata == DATA_W'(err_q));

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
        end else begin
            stat_q <= stat_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (wr_enset) begin
            cfg_q.en    <= cfg_q.en | (wdata[SRC_W-1:0] & SRC_MASK);
            cfg_q.steer <= wdata[STEER_LSB +: STEER_W];
        end else if (wr_enclr) begin
            cfg_q.en    <= cfg_q.en & ~wdata[SRC_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= '0;
        end else if (err_vld) begin
            err_q <= err_code;
        end else if (wr_err && err_match) begin
            err_q <= '0;
        end
    end

    assign pending = |(stat_q & cfg_q.en);

    // R2: unimplemented positions never hold a bit
    p_unused_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (stat_q & ~SRC_MASK) == '0);

    // R3: an event is visible next cycle whatever the acknowledge did
    p_event_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        (|(ev & SRC_MASK)) |=> ((stat_q & $past(ev & SRC_MASK)) == $past(ev & SRC_MASK)));

    // R4: without events, acknowledged bits drop and the rest hold
    p_ack_clears_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_stat && ev == '0) |=> (stat_q == ($past(stat_q) & ~$past(ack_bits(wdata)))));

    // R7: steering only moves on a set-address write
    p_steer_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !wr_enset |=> $stable(cfg_q.steer));

    // R10: a matching write-back without a load empties the code
    p_err_clear_r10: assert property (@(posedge clk) disable iff (rst)
        (wr_err && err_match && !err_vld) |=> (err_q == '0));

endmodule

// File: rtl/irqhub_host.sv
module irqhub_host
    import irqhub_pkg::*;
#(
    parameter int NPORTS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NPORTS-1:0] pending,
    input  logic              wr_ctl,
    input  logic [DATA_W-1:0] wdata,
    output logic [NPORTS-1:0] host_ctl,
    output logic [NPORTS-1:0] irq
);

    always_ff @(posedge clk) begin
        if (rst) begin
            host_ctl <= '0;
        end else if (wr_ctl) begin
            host_ctl <= wdata[NPORTS-1:0];
        end
    end

    for (genvar p = 0; p < NPORTS; p++) begin : g_gate
        assign irq[p] = pending[p] & host_ctl[p];
    end

    // R1: reset leaves every port gated off
    p_ctl_reset_r1: assert property (@(posedge clk)
        rst |=> (host_ctl == '0));

    // R9: control register takes the written value
    p_ctl_write_r9: assert property (@(posedge clk) disable iff (rst)
        wr_ctl |=> (host_ctl == $past(wdata[NPORTS-1:0])));

endmodule

// File: rtl/port_irq_hub.sv
module port_irq_hub
    import irqhub_pkg::*;
#(
    parameter int NPORTS = 4,
    parameter int ERR_W  = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NPORTS*SRC_W-1:0] ev_pulse,
    input  logic [NPORTS-1:0]       err_vld,
    input  logic [NPORTS*ERR_W-1:0] err_code,
    input  logic                    bus_wr,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [DATA_W-1:0]       bus_wdata,
    output logic [DATA_W-1:0]       bus_rdata,
    output logic [NPORTS-1:0]       irq,
    output logic [NPORTS*STEER_W-1:0] steer
);

    logic [BLK_W-1:0] blk;
    logic [OFF_W-1:0] off;
    assign blk = bus_addr[ADDR_W-1:OFF_W];
    assign off = bus_addr[OFF_W-1:0];

    logic [SRC_W-1:0] stat_a [NPORTS];
    en_cfg_t          cfg_a  [NPORTS];
    logic [ERR_W-1:0] err_a  [NPORTS];
    logic [NPORTS-1:0] pend;
    logic [NPORTS-1:0] host_ctl;

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        logic sel;
        assign sel = bus_wr && (blk == BLK_W'(p));

        irqhub_port #(.ERR_W(ERR_W)) u_port (
            .clk      (clk),
            .rst      (rst),
            .ev       (ev_pulse[p*SRC_W +: SRC_W]),
            .err_vld  (err_vld[p]),
            .err_code (err_code[p*ERR_W +: ERR_W]),
            .wr_stat  (sel && port_reg_e'(off) == PREG_STAT),
            .wr_enset (sel && port_reg_e'(off) == PREG_ENSET),
            .wr_enclr (sel && port_reg_e'(off) == PREG_ENCLR),
            .wr_err   (sel && port_reg_e'(off) == PREG_ERR),
            .wdata    (bus_wdata),
            .stat_q   (stat_a[p]),
            .cfg_q    (cfg_a[p]),
            .err_q    (err_a[p]),
            .pending  (pend[p])
        );

        assign steer[p*STEER_W +: STEER_W] = cfg_a[p].steer;
    end

    irqhub_host #(.NPORTS(NPORTS)) u_host (
        .clk      (clk),
        .rst      (rst),
        .pending  (pend),
        .wr_ctl   (bus_wr && blk == HOST_BLK && host_reg_e'(off) == HREG_CTL),
        .wdata    (bus_wdata),
        .host_ctl (host_ctl),
        .irq      (irq)
    );

    always_comb begin
        bus_rdata = '0;
        for (int p = 0; p < NPORTS; p++) begin
            if (blk == BLK_W'(p)) begin
                case (port_reg_e'(off))
                    PREG_STAT:  bus_rdata = stat_word(stat_a[p], cfg_a[p].en);
                    PREG_ENSET: bus_rdata = en_word(cfg_a[p]);
                    PREG_ENCLR: bus_rdata = en_word(cfg_a[p]);
                    PREG_ERR:   bus_rdata = DATA_W'(err_a[p]);
                    default:    bus_rdata = '0;
                endcase
            end
        end
        if (blk == HOST_BLK) begin
            case (host_reg_e'(off))
                HREG_STAT: bus_rdata = DATA_W'(pend);
                HREG_CTL:  bus_rdata = DATA_W'(host_ctl);
                default:   bus_rdata = '0;
            endcase
        end
    end

    // R8: no line without an enabled pending request
    p_irq_needs_pend_r8: assert property (@(posedge clk) disable iff (rst)
        (irq & ~pend) == '0);

    // R1: interrupt lines are quiet in the cycle after reset
    p_irq_reset_r1: assert property (@(posedge clk)
        rst |=> (irq == '0));

endmodule

// File: tb/sim_port_irq_hub.sv
`timescale 1ns/1ps
module sim_port_irq_hub;

    localparam int NP = 4;
    localparam int EW = 8;
    localparam int SW = 12;
    localparam logic [11:0] IMPL = 12'h87F;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NP*SW-1:0]  ev_pulse = '0;
    logic [NP-1:0]     err_vld = '0;
    logic [NP*EW-1:0]  err_code = '0;
    logic              bus_wr = 1'b0;
    logic [5:0]        bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [NP-1:0]     irq;
    logic [NP*2-1:0]   steer;

    always #4 clk = ~clk;

    port_irq_hub #(.NPORTS(NP), .ERR_W(EW)) u0 (
        .clk(clk), .rst(rst), .ev_pulse(ev_pulse), .err_vld(err_vld),
        .err_code(err_code), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .steer(steer)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [11:0]  m_stat [NP];
    logic [11:0]  m_en   [NP];
    logic [1:0]   m_st   [NP];
    logic [EW-1:0] m_err [NP];
    logic [NP-1:0] m_hc;

    task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [NP-1:0] m_pend();
        logic [NP-1:0] r;
        for (int p = 0; p < NP; p++) r[p] = |(m_stat[p] & m_en[p]);
        return r;
    endfunction

    function automatic logic [31:0] exp_rd(input logic [5:0] a);
        int p;
        p = int'(a[5:3]);
        if (p < NP) begin
            case (a[2:0])
                3'd0: return {4'h0, m_stat[p], 4'h0, m_stat[p] & m_en[p]};
                3'd1, 3'd2: return {m_st[p], 18'h0, m_en[p]};
                3'd3: return {{(32-EW){1'b0}}, m_err[p]};
                default: return 32'h0;
            endcase
        end
        if (a[5:3] == 3'd7) begin
            if (a[2:0] == 3'd0) return {{(32-NP){1'b0}}, m_pend()};
            if (a[2:0] == 3'd1) return {{(32-NP){1'b0}}, m_hc};
        end
        return 32'h0;
    endfunction

    // One bus cycle with optional events and error loads in the same cycle
    task automatic cyc(input logic [NP*SW-1:0] ev, input logic [NP-1:0] ee,
                       input logic [NP*EW-1:0] ec, input logic w,
                       input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        ev_pulse = ev; err_vld = ee; err_code = ec;
        bus_wr = w; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        ev_pulse = '0; err_vld = '0; bus_wr = 1'b0;
        for (int p = 0; p < NP; p++) begin
            if (w && int'(a[5:3]) == p) begin
                case (a[2:0])
                    3'd0: m_stat[p] = m_stat[p] & ~((d[11:0] | d[27:16]) & IMPL);
                    3'd1: begin m_en[p] = m_en[p] | (d[11:0] & IMPL); m_st[p] = d[31:30]; end
                    3'd2: m_en[p] = m_en[p] & ~d[11:0];
                    3'd3: if (d == {{(32-EW){1'b0}}, m_err[p]}) m_err[p] = '0;
                    default: ;
                endcase
            end
            m_stat[p] = m_stat[p] | (ev[p*SW +: SW] & IMPL);
            if (ee[p]) m_err[p] = ec[p*EW +: EW];
        end
        if (w && a == {3'd7, 3'd1}) m_hc = d[NP-1:0];
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        cyc('0, '0, '0, 1'b1, a, d);
    endtask

    task automatic pulse(input int p, input logic [11:0] bits);
        logic [NP*SW-1:0] v;
        v = '0;
        v[p*SW +: SW] = bits;
        cyc(v, '0, '0, 1'b0, 6'h0, 32'h0);
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic check_all(input string ctx);
        logic [31:0] v;
        for (int p = 0; p < NP; p++) begin
            rd({3'(p), 3'd0}, v); chk(v, exp_rd({3'(p), 3'd0}), $sformatf("R5 %s port%0d status", ctx, p));
            rd({3'(p), 3'd1}, v); chk(v, exp_rd({3'(p), 3'd1}), $sformatf("R6 %s port%0d enset", ctx, p));
            rd({3'(p), 3'd2}, v); chk(v, exp_rd({3'(p), 3'd2}), $sformatf("R6 %s port%0d enclr", ctx, p));
            rd({3'(p), 3'd3}, v); chk(v, exp_rd({3'(p), 3'd3}), $sformatf("R10 %s port%0d err", ctx, p));
            chk(32'(steer[p*2 +: 2]), 32'(m_st[p]), $sformatf("R7 %s port%0d steer", ctx, p));
        end
        rd(6'o70, v); chk(v, exp_rd(6'o70), $sformatf("R9 %s host status", ctx));
        rd(6'o71, v); chk(v, exp_rd(6'o71), $sformatf("R9 %s host ctl", ctx));
        chk(32'(irq), 32'(m_pend() & m_hc), $sformatf("R8 %s irq", ctx));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [NP*SW-1:0] evv;
        logic [NP*EW-1:0] ecv;
        for (int p = 0; p < NP; p++) begin
            m_stat[p] = '0; m_en[p] = '0; m_st[p] = '0; m_err[p] = '0;
        end
        m_hc = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        chk(32'(irq), 32'h0, "R1 irq after reset");
        rd(6'o00, v); chk(v, 32'h0, "R1 port0 status after reset");
        rd(6'o71, v); chk(v, 32'h0, "R1 host ctl after reset");
        check_all("reset");

        // R2: sweep every event position on every port
        wr(6'o71, 32'hF);
        for (int p = 0; p < NP; p++) begin
            wr({3'(p), 3'd1}, 32'h0000_0FFF);
            for (int b = 0; b < 12; b++) begin
                pulse(p, 12'(1 << b));
                rd({3'(p), 3'd0}, v);
                chk(v, (IMPL[b] ? (32'(1) << b) | (32'(1) << (b + 16)) : 32'h0),
                    $sformatf("R2 port%0d bit%0d", p, b));
                chk(32'(irq[p]), 32'(IMPL[b]), $sformatf("R8 port%0d bit%0d irq", p, b));
                wr({3'(p), 3'd0}, 32'h0FFF_0FFF);
                rd({3'(p), 3'd0}, v);
                chk(v, 32'h0, $sformatf("R4 port%0d bit%0d ack all", p, b));
            end
        end

        // R5/R6/R7: enable and steering patterns with all events raised
        for (int p = 0; p < NP; p++) begin
            for (int k = 0; k < 8; k++) begin
                wr({3'(p), 3'd2}, 32'h0000_0FFF);
                wr({3'(p), 3'd1}, {2'(k), 18'h0, 12'((k * 12'h1A5 + p * 12'h033) & 12'hFFF)});
                pulse(p, 12'hFFF);
                check_all($sformatf("pattern%0d", k));
                wr({3'(p), 3'd2}, 32'hC000_0000 | 32'(12'(k * 12'h0C3)));
                check_all($sformatf("partclr%0d", k));
                wr({3'(p), 3'd0}, 32'h0FFF_0FFF);
            end
        end

        // R3: event and acknowledge of the same bit collide
        wr(6'o11, 32'h0000_0FFF);
        pulse(1, 12'h002);
        evv = '0; evv[1*SW +: SW] = 12'h001;
        cyc(evv, '0, '0, 1'b1, 6'o10, 32'h0000_0003);
        rd(6'o10, v);
        chk(v, 32'h0001_0001, "R3 colliding event kept, other bit acked");

        // R4: acknowledge through the upper half only
        pulse(2, 12'h870);
        wr(6'o20, 32'h0010_0000);
        rd(6'o20, v);
        chk(v[27:16], 12'h860, "R4 upper-half ack clears bit 4");
        wr(6'o20, 32'h0000_0000);
        rd(6'o20, v);
        chk(v[27:16], 12'h860, "R4 zero write changes nothing");
        check_all("ack");

        // R9/R8: every host control value over mixed pending ports
        wr(6'o30, 32'h0FFF_0FFF);
        pulse(0, 12'h001); pulse(2, 12'h800); pulse(3, 12'h040);
        wr(6'o31, 32'h0000_0FFF);
        for (int h = 0; h < 16; h++) begin
            wr(6'o71, 32'(h));
            check_all($sformatf("hctl%0d", h));
        end

        // R10: error code load, mismatch, match, load-over-clear
        ecv = '0; ecv[2*EW +: EW] = 8'h5A;
        cyc('0, 4'b0100, ecv, 1'b0, 6'h0, 32'h0);
        rd(6'o23, v); chk(v, 32'h5A, "R10 load");
        wr(6'o23, 32'h5B);
        rd(6'o23, v); chk(v, 32'h5A, "R10 mismatched write ignored");
        wr(6'o23, 32'h5A);
        rd(6'o23, v); chk(v, 32'h0, "R10 matching write clears");
        cyc('0, 4'b0100, ecv, 1'b0, 6'h0, 32'h0);
        ecv[2*EW +: EW] = 8'h21;
        cyc('0, 4'b0100, ecv, 1'b1, 6'o23, 32'h5A);
        rd(6'o23, v); chk(v, 32'h21, "R10 load wins over clear");

        // R7: clear-address write with steering bits set leaves steering
        wr(6'o01, 32'h8000_0000);
        wr(6'o02, 32'hC000_0000);
        chk(32'(steer[1:0]), 32'h2, "R7 steer kept on clear write");
        rd(6'o02, v); chk(v[31:30], 2'b10, "R7 steer readable");
        check_all("final");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule